// File: doc/BRIEF.md
# Disk Target Phase Sequencer

This block is the bus-phase engine of a simplified parallel-bus disk target. It watches the initiator's control lines and moves through the bus phases in turn. It arbitrates and responds to selection. When the initiator holds the attention line, it takes one message byte first. It then collects a command block over a request/acknowledge handshake and decodes it to pick the data direction and the byte count. It moves the data over a DMA request/acknowledge handshake. It finishes with a good status byte and a command-complete message before it releases the bus.

The block stores no media. During data-in it publishes a byte index (`src_idx`) and the decoded block address (`xfer_lba`), and an external byte source returns the byte on `src_data`. A command whose length and opcode group mark it as complete, but which is not one the block supports, raises `cmd_unsupported`, and the sequencer stays in the command phase until a bus reset.

Top module: `disk_target_seq`

## Requirements
- R1: `rst_n` low, or `bus_rst` high at a clock edge, puts the sequencer in bus free after that edge, with `tgt_bsy`, `tgt_req`, `drq` and all three phase lines low. This overrides every other state.
- R2: From bus free, `ini_sel` high moves the sequencer to arbitration on the next edge. From arbitration, the sequencer enters selection and raises `tgt_bsy` only when `ini_sel`=1, `ini_bsy`=0, `data_drive`=1 and `ini_data` bit 6 (the target ID bit) = 1. If `ini_sel` and `ini_bsy` are both low, it returns to bus free. Otherwise it waits in arbitration.
- R3: From selection, with `ini_atn`=1 the sequencer enters message out ({MSG,C/D,I/O}=110) with `tgt_req` high. After one handshake it enters command (010). With `ini_atn`=0 it enters command directly.
- R4: In the command and message phases, `tgt_req` rises while `ini_ack` is low. When `tgt_req` and `ini_ack` are both high, the byte on `ini_data` is taken and `tgt_req` falls on the next edge.
- R5: Six-byte commands are recognised as follows. Opcode 0x00 goes straight to status. Opcodes 0x03, 0x12 and 0x1A go to data-in with byte 4 as the count. Opcode 0x08 goes to data-in with byte 4 × 512 as the count. Opcode 0x15 goes to data-out with byte 4 as the count.
- R6: Ten-byte commands are recognised as follows. Opcode 0x25 goes to data-in for 8 bytes. Opcode 0x28 goes to data-in for {byte 7, byte 8} × 512 bytes, and `xfer_lba` takes {byte 2, byte 3, byte 4, byte 5}. For every other command `xfer_lba` is 0.
- R7: A complete command that is not supported raises `cmd_unsupported`, and the sequencer stays in the command phase. A command counts as complete at 6 bytes when the opcode's top three bits are 000, and at 10 bytes when they are 001 or 010.
- R8: Data-in is {MSG,C/D,I/O}=001 and data-out is 000. While `dack` is low, `drq` is raised and, for data-in, `tgt_data` is loaded with `src_data` at the current `src_idx` (starting at 0). Each edge with `drq` and `dack` both high drops `drq`, increments `src_idx` and decrements the remaining count. The edge that consumes the last byte drops `tgt_req` and enters status.
- R9: Status (011) and message in (111) drive `tgt_data`=0x00 and raise `tgt_req` while `ini_ack` is low. An acknowledge in status moves the sequencer to message in. An acknowledge in message in returns it to bus free with the phase lines low and `tgt_bsy` released.
- R10: A recognised data command whose count decodes to zero skips the data phase and enters status directly.
- R11: While `dma_en` is low, `drq` stays low and no byte is transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Bus reset line from the initiator |
| ini_sel | input | 1 | Initiator select line |
| ini_bsy | input | 1 | Initiator busy line |
| ini_atn | input | 1 | Initiator attention line |
| ini_ack | input | 1 | Initiator acknowledge |
| data_drive | input | 1 | Initiator is driving the data bus |
| ini_data | input | 8 | Data bus as driven by the initiator |
| dma_en | input | 1 | DMA transfer enable |
| dack | input | 1 | DMA acknowledge |
| src_data | input | 8 | Byte from the external source at `src_idx` |
| tgt_bsy | output | 1 | Target busy |
| tgt_req | output | 1 | Target request |
| ph_msg | output | 1 | Phase line MSG |
| ph_cd | output | 1 | Phase line C/D |
| ph_io | output | 1 | Phase line I/O |
| tgt_data | output | 8 | Data driven by the target |
| drq | output | 1 | DMA request |
| src_idx | output | LEN_W | Byte index within the current transfer |
| xfer_lba | output | 32 | Block address of the current transfer |
| cmd_unsupported | output | 1 | Complete but unsupported command is held |

## Verification
Some rules are checked on every cycle. A bus reset clears the bus-facing outputs on the next edge, and busy rises only after a valid selection. Request falls after an acknowledge in the command, status and message phases. DMA requests appear only in data phases and never while DMA is disabled, each DMA acknowledge lowers the remaining count by exactly one, status and message bytes are zero, and the unsupported flag appears only in the command phase. The bench scenarios cover what no single-cycle rule can show: the phase order for each supported opcode, the exact byte count across a sweep of allocation lengths and block counts, the data bytes fetched from the source, the decoded block address, the zero-length shortcut, and the selection paths that must not grant busy.

// File: rtl/disk_seq_pkg.sv
package disk_seq_pkg;

    typedef enum logic [3:0] {
        ST_FREE,
        ST_ARB,
        ST_SEL,
        ST_MSGO,
        ST_CMD,
        ST_DIN,
        ST_DOUT,
        ST_STAT,
        ST_MSGI
    } seq_state_t;

    localparam logic [7:0] OP_UNIT_READY = 8'h00;
    localparam logic [7:0] OP_SENSE      = 8'h03;
    localparam logic [7:0] OP_READ_SHORT = 8'h08;
    localparam logic [7:0] OP_IDENTIFY   = 8'h12;
    localparam logic [7:0] OP_MODE_SET   = 8'h15;
    localparam logic [7:0] OP_MODE_GET   = 8'h1A;
    localparam logic [7:0] OP_CAPACITY   = 8'h25;
    localparam logic [7:0] OP_READ_LONG  = 8'h28;

    // Only the command bytes the decoder reads are kept.
    typedef struct packed {
        logic [7:0] op;
        logic [7:0] b2;
        logic [7:0] b3;
        logic [7:0] b4;
        logic [7:0] b5;
        logic [7:0] b7;
        logic [7:0] b8;
    } cmd_fields_t;

endpackage

// File: rtl/disk_cmd_capture.sv
module disk_cmd_capture
    import disk_seq_pkg::*;
#(
    parameter int MAX_BYTES = 10,
    localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [7:0]       din,
    output logic [CNT_W-1:0] count,
    output cmd_fields_t      fields
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            fields <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (push && count != CNT_W'(MAX_BYTES)) begin
            count <= count + CNT_W'(1);
            case (count)
                CNT_W'(0): fields.op <= din;
                CNT_W'(2): fields.b2 <= din;
                CNT_W'(3): fields.b3 <= din;
                CNT_W'(4): fields.b4 <= din;
                CNT_W'(5): fields.b5 <= din;
                CNT_W'(7): fields.b7 <= din;
                CNT_W'(8): fields.b8 <= din;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/disk_cmd_decode.sv
module disk_cmd_decode
    import disk_seq_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int LEN_W     = 25,
    parameter int BLK_SHIFT = 9
) (
    input  cmd_fields_t      f,
    input  logic [CNT_W-1:0] cnt,
    output logic             match,
    output logic             to_status,
    output logic             dir_in,
    output logic             unsupported,
    output logic [LEN_W-1:0] len,
    output logic [31:0]      lba
);

    logic six, ten, stat_only;

    assign six = (cnt == CNT_W'(6));
    assign ten = (cnt == CNT_W'(10));

    always_comb begin
        match     = 1'b0;
        stat_only = 1'b0;
        dir_in    = 1'b1;
        len       = '0;
        lba       = '0;
        case (f.op)
            OP_UNIT_READY: if (six) begin
                match     = 1'b1;
                stat_only = 1'b1;
            end
            OP_SENSE, OP_IDENTIFY, OP_MODE_GET: if (six) begin
                match = 1'b1;
                len   = LEN_W'(f.b4);
            end
            OP_READ_SHORT: if (six) begin
                match = 1'b1;
                len   = LEN_W'(f.b4) << BLK_SHIFT;
            end
            OP_MODE_SET: if (six) begin
                match  = 1'b1;
                dir_in = 1'b0;
                len    = LEN_W'(f.b4);
            end
            OP_CAPACITY: if (ten) begin
                match = 1'b1;
                len   = LEN_W'(8);
            end
            OP_READ_LONG: if (ten) begin
                match = 1'b1;
                len   = LEN_W'({f.b7, f.b8}) << BLK_SHIFT;
                lba   = {f.b2, f.b3, f.b4, f.b5};
            end
            default: ;
        endcase
    end

    assign to_status   = match && (stat_only || len == '0);
    assign unsupported = !match &&
                         ((six && f.op[7:5] == 3'd0) ||
                          (ten && (f.op[7:5] == 3'd1 || f.op[7:5] == 3'd2)));

endmodule

// File: rtl/disk_target_seq.sv
module disk_target_seq
    import disk_seq_pkg::*;
#(
    parameter int CMD_MAX   = 10,
    parameter int LEN_W     = 25,
    parameter int TGT_ID    = 6,
    parameter int BLK_SHIFT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst,
    input  logic             ini_sel,
    input  logic             ini_bsy,
    input  logic             ini_atn,
    input  logic             ini_ack,
    input  logic             data_drive,
    input  logic [7:0]       ini_data,
    input  logic             dma_en,
    input  logic             dack,
    input  logic [7:0]       src_data,
    output logic             tgt_bsy,
    output logic             tgt_req,
    output logic             ph_msg,
    output logic             ph_cd,
    output logic             ph_io,
    output logic [7:0]       tgt_data,
    output logic             drq,
    output logic [LEN_W-1:0] src_idx,
    output logic [31:0]      xfer_lba,
    output logic             cmd_unsupported
);

    localparam int CNT_W = $clog2(CMD_MAX + 1);

    seq_state_t       st_q, st_n;
    logic             req_q, req_n, drq_q, drq_n, bsy_q, bsy_n;
    logic [7:0]       dout_q, dout_n;
    logic [LEN_W-1:0] rem_q, rem_n, idx_q, idx_n;
    logic [31:0]      lba_q, lba_n;

    logic             cap_clear, cap_push;
    logic [CNT_W-1:0] cmd_cnt;
    cmd_fields_t      fields;
    logic             dec_match, dec_stat, dec_in, dec_bad;
    logic [LEN_W-1:0] dec_len;
    logic [31:0]      dec_lba;

    disk_cmd_capture #(.MAX_BYTES(CMD_MAX)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cap_clear),
        .push   (cap_push),
        .din    (ini_data),
        .count  (cmd_cnt),
        .fields (fields)
    );

    disk_cmd_decode #(.CNT_W(CNT_W), .LEN_W(LEN_W), .BLK_SHIFT(BLK_SHIFT)) u_dec (
        .f           (fields),
        .cnt         (cmd_cnt),
        .match       (dec_match),
        .to_status   (dec_stat),
        .dir_in      (dec_in),
        .unsupported (dec_bad),
        .len         (dec_len),
        .lba         (dec_lba)
    );

    // Next-state and next-output logic
    always_comb begin
        st_n      = st_q;
        req_n     = req_q;
        drq_n     = drq_q;
        bsy_n     = bsy_q;
        dout_n    = dout_q;
        rem_n     = rem_q;
        idx_n     = idx_q;
        lba_n     = lba_q;
        cap_clear = 1'b0;
        cap_push  = 1'b0;
        if (bus_rst) begin
            st_n  = ST_FREE;
            bsy_n = 1'b0;
            req_n = 1'b0;
            drq_n = 1'b0;
        end else begin
            unique case (st_q)
                ST_FREE: if (ini_sel) st_n = ST_ARB;
                ST_ARB: begin
                    if (!ini_bsy && ini_sel && data_drive && ini_data[TGT_ID]) begin
                        st_n  = ST_SEL;
                        bsy_n = 1'b1;
                    end else if (!ini_bsy && !ini_sel) begin
                        st_n = ST_FREE;
                    end
                end
                ST_SEL: begin
                    cap_clear = 1'b1;
                    if (ini_atn) begin
                        st_n  = ST_MSGO;
                        req_n = 1'b1;
                    end else begin
                        st_n = ST_CMD;
                    end
                end
                ST_MSGO: if (req_q && ini_ack) begin
                    req_n     = 1'b0;
                    cap_clear = 1'b1;
                    st_n      = ST_CMD;
                end
                ST_CMD: begin
                    if (!ini_ack) req_n = 1'b1;
                    else if (req_q && !dec_match) begin
                        cap_push = 1'b1;
                        req_n    = 1'b0;
                    end
                    if (dec_match) begin
                        req_n = 1'b0;
                        drq_n = 1'b0;
                        rem_n = dec_len;
                        idx_n = '0;
                        lba_n = dec_lba;
                        st_n  = dec_stat ? ST_STAT : (dec_in ? ST_DIN : ST_DOUT);
                    end
                end
                ST_DIN, ST_DOUT: begin
                    if (!ini_ack) req_n = 1'b1;
                    if (!dma_en) begin
                        drq_n = 1'b0;
                    end else if (!dack) begin
                        drq_n = 1'b1;
                        if (st_q == ST_DIN) dout_n = src_data;
                    end else if (drq_q) begin
                        drq_n = 1'b0;
                        rem_n = rem_q - LEN_W'(1);
                        idx_n = idx_q + LEN_W'(1);
                        if (rem_q == LEN_W'(1)) begin
                            req_n = 1'b0;
                            st_n  = ST_STAT;
                        end
                    end
                end
                ST_STAT, ST_MSGI: begin
                    dout_n = 8'h00;
                    if (!ini_ack) req_n = 1'b1;
                    else if (req_q) begin
                        req_n = 1'b0;
                        if (st_q == ST_STAT) begin
                            st_n = ST_MSGI;
                        end else begin
                            st_n  = ST_FREE;
                            bsy_n = 1'b0;
                        end
                    end
                end
                default: st_n = ST_FREE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_FREE;
            req_q  <= 1'b0;
            drq_q  <= 1'b0;
            bsy_q  <= 1'b0;
            dout_q <= '0;
            rem_q  <= '0;
            idx_q  <= '0;
            lba_q  <= '0;
        end else begin
            st_q   <= st_n;
            req_q  <= req_n;
            drq_q  <= drq_n;
            bsy_q  <= bsy_n;
            dout_q <= dout_n;
            rem_q  <= rem_n;
            idx_q  <= idx_n;
            lba_q  <= lba_n;
        end
    end

    // Outputs
    always_comb begin
        {ph_msg, ph_cd, ph_io} = 3'b000;
        unique case (st_q)
            ST_MSGO: {ph_msg, ph_cd, ph_io} = 3'b110;
            ST_CMD:  {ph_msg, ph_cd, ph_io} = 3'b010;
            ST_DIN:  {ph_msg, ph_cd, ph_io} = 3'b001;
            ST_STAT: {ph_msg, ph_cd, ph_io} = 3'b011;
            ST_MSGI: {ph_msg, ph_cd, ph_io} = 3'b111;
            default: {ph_msg, ph_cd, ph_io} = 3'b000;
        endcase
    end

    assign tgt_bsy         = bsy_q;
    assign tgt_req         = req_q;
    assign drq             = drq_q;
    assign tgt_data        = dout_q;
    assign src_idx         = idx_q;
    assign xfer_lba        = lba_q;
    assign cmd_unsupported = (st_q == ST_CMD) && dec_bad;

endmodule

// File: rtl/disk_target_seq_chk.sv
module disk_target_seq_chk #(
    parameter int LEN_W = 25
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rst,
    input logic             ini_sel,
    input logic             ini_bsy,
    input logic             ini_ack,
    input logic             data_drive,
    input logic             id_bit,
    input logic             dma_en,
    input logic             dack,
    input logic             tgt_bsy,
    input logic             tgt_req,
    input logic             ph_msg,
    input logic             ph_cd,
    input logic             ph_io,
    input logic [7:0]       tgt_data,
    input logic             drq,
    input logic             cmd_unsupported,
    input logic [LEN_W-1:0] rem
);

    a_r1_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (!tgt_bsy && !tgt_req && !drq && !ph_msg && !ph_cd && !ph_io));

    a_r2_bsy_after_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_bsy) |-> $past(ini_sel && !ini_bsy && data_drive && id_bit && !bus_rst));

    a_r4_req_falls_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && ini_ack && ph_cd) |=> !tgt_req);

    a_r7_flag_in_command: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_unsupported |-> (!ph_msg && ph_cd && !ph_io));

    a_r8_drq_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        drq |-> (!ph_msg && !ph_cd));

    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (drq && dack && dma_en && !bus_rst) |=> (rem == $past(rem) - LEN_W'(1)));

    a_r9_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && ph_cd && ph_io) |-> (tgt_data == 8'h00));

    a_r11_dma_off: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> !drq);

endmodule

bind disk_target_seq disk_target_seq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_rst         (bus_rst),
    .ini_sel         (ini_sel),
    .ini_bsy         (ini_bsy),
    .ini_ack         (ini_ack),
    .data_drive      (data_drive),
    .id_bit          (ini_data[TGT_ID]),
    .dma_en          (dma_en),
    .dack            (dack),
    .tgt_bsy         (tgt_bsy),
    .tgt_req         (tgt_req),
    .ph_msg          (ph_msg),
    .ph_cd           (ph_cd),
    .ph_io           (ph_io),
    .tgt_data        (tgt_data),
    .drq             (drq),
    .cmd_unsupported (cmd_unsupported),
    .rem             (rem_q)
);

// File: tb/disk_target_seq_test.sv
module disk_target_seq_test;

    localparam int LEN_W = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rst = 1'b0, ini_sel = 1'b0, ini_bsy = 1'b0, ini_atn = 1'b0, ini_ack = 1'b0;
    logic data_drive = 1'b0, dma_en = 1'b1, dack = 1'b0;
    logic [7:0] ini_data = 8'h00;
    logic [7:0] src_data;
    logic tgt_bsy, tgt_req, ph_msg, ph_cd, ph_io, drq, cmd_unsupported;
    logic [7:0] tgt_data;
    logic [LEN_W-1:0] src_idx;
    logic [31:0] xfer_lba;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // External byte source: pattern from index and block address
    assign src_data = src_idx[7:0] ^ src_idx[15:8] ^ xfer_lba[7:0] ^ 8'h5A;

    disk_target_seq uut (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .ini_sel(ini_sel), .ini_bsy(ini_bsy),
        .ini_atn(ini_atn), .ini_ack(ini_ack), .data_drive(data_drive), .ini_data(ini_data),
        .dma_en(dma_en), .dack(dack), .src_data(src_data), .tgt_bsy(tgt_bsy),
        .tgt_req(tgt_req), .ph_msg(ph_msg), .ph_cd(ph_cd), .ph_io(ph_io),
        .tgt_data(tgt_data), .drq(drq), .src_idx(src_idx), .xfer_lba(xfer_lba),
        .cmd_unsupported(cmd_unsupported)
    );

    function automatic logic [2:0] phase();
        return {ph_msg, ph_cd, ph_io};
    endfunction

    function automatic logic [79:0] mk(input logic [7:0] op, input logic [7:0] b2,
                                       input logic [7:0] b3, input logic [7:0] b4,
                                       input logic [7:0] b5, input logic [7:0] b7,
                                       input logic [7:0] b8);
        logic [79:0] c = '0;
        c[7:0] = op; c[23:16] = b2; c[31:24] = b3; c[39:32] = b4;
        c[47:40] = b5; c[63:56] = b7; c[71:64] = b8;
        return c;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_req(input string tag);
        int t = 0;
        while (!tgt_req && t < 64) begin
            tick();
            t++;
        end
        if (!tgt_req) chk(1'b0, tag, 0, 1);
    endtask

    task automatic xfer_byte(input logic [7:0] b);
        wait_req("R4 request never rose");
        ini_data = b;
        ini_ack = 1'b1;
        tick();
        chk(!tgt_req, "R4 request after ack", tgt_req, 0);
        ini_ack = 1'b0;
        tick();
    endtask

    task automatic select_tgt(input bit atn);
        ini_atn = atn; ini_sel = 1'b1; ini_bsy = 1'b0;
        data_drive = 1'b1; ini_data = 8'h41;
        tick(3);
        ini_sel = 1'b0; data_drive = 1'b0; ini_atn = 1'b0;
    endtask

    task automatic run_data(input bit din, input int exp_len, input logic [31:0] lba,
                            input string tag);
        int n = 0;
        int bad = 0;
        chk(phase() == {2'b00, din}, {"R8 data phase ", tag}, phase(), {2'b00, din});
        while (!ph_cd) begin
            if (drq) begin
                if (din) begin
                    logic [7:0] e;
                    e = 8'(n) ^ 8'(n >> 8) ^ lba[7:0] ^ 8'h5A;
                    if (tgt_data !== e) bad++;
                end
                dack = 1'b1;
                tick();
                dack = 1'b0;
                n++;
            end
            tick();
        end
        chk(n == exp_len, {"R8 byte count ", tag}, n, exp_len);
        chk(bad == 0, {"R8 data bytes ", tag}, bad, 0);
    endtask

    task automatic finish_tail(input string tag);
        wait_req("R9 status request");
        chk(phase() == 3'b011 && tgt_data == 8'h00, {"R9 status ", tag}, {phase(), tgt_data}, 11'h300);
        ini_ack = 1'b1; tick(); ini_ack = 1'b0; tick();
        wait_req("R9 message request");
        chk(phase() == 3'b111 && tgt_data == 8'h00, {"R9 message in ", tag}, {phase(), tgt_data}, 11'h700);
        ini_ack = 1'b1; tick(); ini_ack = 1'b0; tick();
        chk(!tgt_bsy && phase() == 3'b000, {"R9 bus free ", tag}, {tgt_bsy, phase()}, 0);
    endtask

    task automatic run_cmd(input bit atn, input logic [79:0] c, input int n, input bit din,
                           input int exp_len, input logic [31:0] lba, input string tag);
        select_tgt(atn);
        chk(tgt_bsy, {"R2 busy after selection ", tag}, tgt_bsy, 1);
        if (atn) begin
            chk(phase() == 3'b110 && tgt_req, {"R3 message out ", tag}, {tgt_req, phase()}, 4'hE);
            xfer_byte(8'hC0);
        end
        chk(phase() == 3'b010, {"R3 command phase ", tag}, phase(), 3'b010);
        for (int i = 0; i < n; i++) xfer_byte(c[8*i +: 8]);
        chk(xfer_lba == lba, {"R6 block address ", tag}, xfer_lba, lba);
        if (exp_len == 0)
            chk(phase() == 3'b011, {"R10 direct to status ", tag}, phase(), 3'b011);
        else
            run_data(din, exp_len, lba, tag);
        finish_tail(tag);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(!tgt_bsy && !tgt_req && !drq && phase() == 3'b000 && !cmd_unsupported,
            "R1 reset state", {tgt_bsy, tgt_req, drq, phase()}, 0);

        // R2 arbitration without data drive, then with a wrong ID bit
        ini_sel = 1'b1; data_drive = 1'b0; ini_data = 8'h40;
        tick(3);
        chk(!tgt_bsy, "R2 no busy without data drive", tgt_bsy, 0);
        data_drive = 1'b1; ini_data = 8'h21;
        tick(2);
        chk(!tgt_bsy, "R2 no busy for other ID", tgt_bsy, 0);
        ini_sel = 1'b0; data_drive = 1'b0;
        tick();
        // back in bus free: selection needs two edges
        ini_sel = 1'b1; data_drive = 1'b1; ini_data = 8'h40;
        tick();
        chk(!tgt_bsy, "R2 one edge from bus free", tgt_bsy, 0);
        tick();
        chk(tgt_bsy, "R2 busy after second edge", tgt_bsy, 1);
        ini_sel = 1'b0; data_drive = 1'b0;
        bus_rst = 1'b1; tick(); bus_rst = 1'b0; tick();
        chk(!tgt_bsy && phase() == 3'b000, "R1 bus reset frees", {tgt_bsy, phase()}, 0);

        run_cmd(1'b0, mk(8'h00, 0, 0, 0, 0, 0, 0), 6, 1'b1, 0, 32'h0, "R5 unit ready");

        // R5 allocation-length sweep for the identify-type command
        for (int k = 0; k < 6; k++) begin
            int lens[6] = '{1, 2, 5, 36, 128, 255};
            run_cmd(k[0], mk(8'h12, 0, 0, 8'(lens[k]), 0, 0, 0), 6, 1'b1, lens[k], 32'h0,
                    "R5 identify sweep");
        end
        run_cmd(1'b1, mk(8'h03, 0, 0, 8'd18, 0, 0, 0), 6, 1'b1, 18, 32'h0, "R5 sense");
        run_cmd(1'b0, mk(8'h1A, 0, 0, 8'd12, 0, 0, 0), 6, 1'b1, 12, 32'h0, "R5 mode get");
        run_cmd(1'b1, mk(8'h15, 0, 0, 8'd20, 0, 0, 0), 6, 1'b0, 20, 32'h0, "R5 mode set out");
        run_cmd(1'b0, mk(8'h08, 0, 0, 8'd1, 0, 0, 0), 6, 1'b1, 512, 32'h0, "R5 short read");
        run_cmd(1'b1, mk(8'h25, 0, 0, 0, 0, 0, 0), 10, 1'b1, 8, 32'h0, "R6 capacity");
        run_cmd(1'b0, mk(8'h28, 8'h12, 8'h34, 8'h56, 8'h78, 8'h00, 8'h02), 10, 1'b1, 1024,
                32'h12345678, "R6 long read");
        run_cmd(1'b0, mk(8'h12, 0, 0, 8'd0, 0, 0, 0), 6, 1'b1, 0, 32'h0, "R10 zero identify");
        run_cmd(1'b1, mk(8'h28, 8'hAB, 0, 0, 8'h01, 0, 0), 10, 1'b1, 0, 32'hAB000001,
                "R10 zero-block read");

        // R7 unsupported six-byte command
        select_tgt(1'b0);
        for (int i = 0; i < 6; i++) xfer_byte(i == 0 ? 8'h01 : 8'h00);
        chk(cmd_unsupported, "R7 flag six-byte", cmd_unsupported, 1);
        tick(5);
        chk(cmd_unsupported && phase() == 3'b010, "R7 stays in command",
            {cmd_unsupported, phase()}, 4'hA);
        bus_rst = 1'b1; tick(); bus_rst = 1'b0; tick();
        chk(!tgt_bsy && phase() == 3'b000 && !cmd_unsupported, "R1 reset from command",
            {tgt_bsy, phase(), cmd_unsupported}, 0);

        // R7 unsupported ten-byte command
        select_tgt(1'b1);
        xfer_byte(8'hC0);
        for (int i = 0; i < 10; i++) xfer_byte(i == 0 ? 8'h2A : 8'h00);
        chk(cmd_unsupported && phase() == 3'b010, "R7 flag ten-byte",
            {cmd_unsupported, phase()}, 4'hA);
        bus_rst = 1'b1; tick(); bus_rst = 1'b0; tick();

        // R11 DMA disabled holds the transfer
        dma_en = 1'b0;
        select_tgt(1'b0);
        for (int i = 0; i < 6; i++) xfer_byte(i == 0 ? 8'h12 : (i == 4 ? 8'd4 : 8'h00));
        tick(10);
        chk(!drq && src_idx == '0 && phase() == 3'b001, "R11 no transfer while disabled",
            {drq, phase()}, 1);
        dma_en = 1'b1;
        run_data(1'b1, 4, 32'h0, "R11 resumed");
        finish_tail("R11");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog expired actual=hang expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule